// File: doc/BRIEF.md
# Branch Target Prediction Table

This block is a small, fully associative table of recently resolved branches. Each entry holds a complete branch address, the target that branch last jumped to, and a two-bit saturating direction counter. In the second fetch stage the pipeline presents the fetch address. One cycle later the block returns a registered answer: whether the address was found, whether the branch is predicted taken, and the next fetch address the next-PC logic should use.

A second port is driven from the first execute stage, where the branch is actually resolved. It carries the branch address, the real outcome, the real target, and the next address that fetch had predicted for that branch. The block trains the matching entry, or allocates a new one when the branch was not found. When the predicted next address differs from the real one, the block raises a flush of the two younger fetch-stage slots and supplies the corrected fetch address. A branch seen for the first time enters the table weakly not taken. Victims are chosen by a round-robin pointer.

Top module: `brt_predictor`

## Requirements
- R1: After reset every entry is invalid, and pred_valid_o, pred_hit_o, pred_taken_o, pred_npc_o, flush_o and redirect_o are all zero.
- R2: A lookup presented with lk_valid high at a clock edge is answered on the outputs after that edge. pred_valid_o equals lk_valid from the previous edge.
- R3: A lookup whose address matches no valid entry returns pred_hit_o=0, pred_taken_o=0 and pred_npc_o = lk_pc + 4.
- R4: A resolved branch that matched no entry is written into the entry selected by the round-robin pointer, with its counter set to 1 (weakly not taken). A later lookup of that address hits and predicts not taken, with pred_npc_o = address + 4.
- R5: The counter saturates at 0 and 3. A taken outcome adds 1 and a not-taken outcome subtracts 1. Values 2 and 3 predict taken, with pred_npc_o equal to the stored target. Values 0 and 1 predict not taken.
- R6: On an update that matches an entry, the stored target is replaced by upd_target only when upd_taken is 1. A not-taken update leaves the stored target unchanged.
- R7: The allocation pointer advances by one for each allocation and wraps after the last entry. Once every entry is in use, the oldest allocation is evicted first.
- R8: When upd_valid is 1 and the real next address (upd_target if taken, otherwise upd_pc + 4) differs from upd_pred_npc, then after the edge flush_o = 2'b11 (bit 0 = first fetch slot, bit 1 = second fetch slot) and redirect_o equals the real next address. Otherwise flush_o and redirect_o are zero after the edge.
- R9: When a lookup and an update touch the same address in the same cycle, the lookup answer reflects the table contents from before that update. This holds for training and for allocation.
- R10: When pred_valid_o is 0, pred_hit_o, pred_taken_o and pred_npc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request from the second fetch stage |
| lk_pc | input | PC_W | Fetch address to look up |
| upd_valid | input | 1 | Resolved branch from the first execute stage |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_target | input | PC_W | Real branch target |
| upd_pred_npc | input | PC_W | Next address that fetch predicted for this branch |
| pred_valid_o | output | 1 | Lookup answer is valid |
| pred_hit_o | output | 1 | Lookup address found in the table |
| pred_taken_o | output | 1 | Predicted taken |
| pred_npc_o | output | PC_W | Predicted next fetch address |
| flush_o | output | 2 | Flush of the younger fetch slots (bit 0 first slot, bit 1 second slot) |
| redirect_o | output | PC_W | Corrected fetch address while flushing |

## Verification
One entry is walked through every counter value with both outcomes. This separates saturation at each end from a plain wrap, and it shows the point where the prediction flips to taken. Updates are applied both with the correct predicted address and with a wrong one, so that a flush raised on every update cannot pass, and neither can a flush that is never raised. Same-cycle lookup and update pairs, one training and one allocating, distinguish old-contents reads from write-through. A run of distinct branches longer than the table, followed by a sweep of lookups over every address used, checks the eviction order of the round-robin pointer.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    localparam logic [1:0] FLUSH_NONE = 2'b00;
    localparam logic [1:0] FLUSH_BOTH = 2'b11;

    // saturating step of the direction counter
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
        else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input logic [1:0] cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/brt_cam.sv
module brt_cam #(
    parameter int N    = 16,
    parameter int W    = 32,
    parameter int IW   = 4
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [N-1:0] match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = vld[g] && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/brt_onehot_dec.sv
module brt_onehot_dec #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          en,
    input  logic [IW-1:0] sel,
    output logic [N-1:0]  onehot
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_dec
            assign onehot[g] = en && (sel == IW'(g));
        end
    endgenerate
endmodule

// File: rtl/brt_predictor.sv
module brt_predictor
    import brt_pkg::*;
#(
    parameter int ENTRIES     = 16,
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic [PC_W-1:0] upd_pred_npc,
    output logic            pred_valid_o,
    output logic            pred_hit_o,
    output logic            pred_taken_o,
    output logic [PC_W-1:0] pred_npc_o,
    output logic [1:0]      flush_o,
    output logic [PC_W-1:0] redirect_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][PC_W-1:0] tag;
        logic [ENTRIES-1:0][PC_W-1:0] tgt;
        logic [ENTRIES-1:0][1:0]      ctr;
        logic [IDX_W-1:0]             ptr;
        logic                         pv;
        logic                         ph;
        logic                         pt;
        logic [PC_W-1:0]              pnpc;
        logic [1:0]                   flush;
        logic [PC_W-1:0]              redir;
    } state_t;

    state_t s_q, s_d;

    logic               lk_hit, up_hit;
    logic [IDX_W-1:0]   lk_idx, up_idx;
    logic [ENTRIES-1:0] alloc_oh;

    brt_cam #(.N(ENTRIES), .W(PC_W), .IW(IDX_W)) u_lk_cam (
        .vld (s_q.vld), .tags(s_q.tag), .key(lk_pc),
        .hit (lk_hit),  .idx (lk_idx)
    );

    brt_cam #(.N(ENTRIES), .W(PC_W), .IW(IDX_W)) u_up_cam (
        .vld (s_q.vld), .tags(s_q.tag), .key(upd_pc),
        .hit (up_hit),  .idx (up_idx)
    );

    brt_onehot_dec #(.N(ENTRIES), .IW(IDX_W)) u_victim (
        .en    (upd_valid && !up_hit),
        .sel   (s_q.ptr),
        .onehot(alloc_oh)
    );

    always_comb begin
        logic [PC_W-1:0] actual_npc;
        logic            mis;
        logic            lk_t;

        s_d = s_q;

        // lookup path: reads only the registered table
        lk_t      = lk_valid && lk_hit && ctr_says_taken(s_q.ctr[lk_idx]);
        s_d.pv    = lk_valid;
        s_d.ph    = lk_valid && lk_hit;
        s_d.pt    = lk_t;
        if (!lk_valid)  s_d.pnpc = '0;
        else if (lk_t)  s_d.pnpc = s_q.tgt[lk_idx];
        else            s_d.pnpc = lk_pc + STEP;

        // resolution check
        actual_npc = upd_taken ? upd_target : upd_pc + STEP;
        mis        = upd_valid && (actual_npc != upd_pred_npc);
        s_d.flush  = mis ? FLUSH_BOTH : FLUSH_NONE;
        s_d.redir  = mis ? actual_npc : '0;

        // training or allocation
        if (upd_valid) begin
            if (up_hit) begin
                s_d.ctr[up_idx] = ctr_step(s_q.ctr[up_idx], upd_taken);
                if (upd_taken) s_d.tgt[up_idx] = upd_target;
            end else begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (alloc_oh[i]) begin
                        s_d.vld[i] = 1'b1;
                        s_d.tag[i] = upd_pc;
                        s_d.tgt[i] = upd_target;
                        s_d.ctr[i] = CTR_WEAK_NT;
                    end
                end
                s_d.ptr = (s_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pred_valid_o = s_q.pv;
    assign pred_hit_o   = s_q.ph;
    assign pred_taken_o = s_q.pt;
    assign pred_npc_o   = s_q.pnpc;
    assign flush_o      = s_q.flush;
    assign redirect_o   = s_q.redir;

endmodule

// File: rtl/brt_predictor_chk.sv
module brt_predictor_chk #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PC_W-1:0] lk_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic [PC_W-1:0] upd_pred_npc,
    input logic            pred_valid_o,
    input logic            pred_hit_o,
    input logic            pred_taken_o,
    input logic [PC_W-1:0] pred_npc_o,
    input logic [1:0]      flush_o,
    input logic [PC_W-1:0] redirect_o
);
    logic [PC_W-1:0] real_npc;
    logic            wrong;
    assign real_npc = upd_taken ? upd_target : upd_pc + PC_W'(INSTR_BYTES);
    assign wrong    = upd_valid && (real_npc != upd_pred_npc);

    p_answer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid_o);
    p_no_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pred_valid_o);
    p_miss_falls_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_o && !pred_hit_o) |-> (!pred_taken_o && pred_npc_o == $past(lk_pc) + PC_W'(INSTR_BYTES)));
    p_taken_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> pred_hit_o);
    p_flush_on_wrong_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrong |=> (flush_o == 2'b11 && redirect_o == $past(real_npc)));
    p_quiet_when_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrong |=> (flush_o == 2'b00 && redirect_o == '0));
    p_idle_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_o |-> (!pred_hit_o && !pred_taken_o && pred_npc_o == '0));
endmodule

bind brt_predictor brt_predictor_chk #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_chk (.*);

// File: tb/brt_predictor_bench.sv
module brt_predictor_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
    logic [31:0] lk_pc = '0, upd_pc = '0, upd_target = '0, upd_pred_npc = '0;
    logic        pred_valid_o, pred_hit_o, pred_taken_o;
    logic [31:0] pred_npc_o, redirect_o;
    logic [1:0]  flush_o;

    int n_chk = 0, n_fail = 0;

    // reference model
    bit          m_vld [N];
    logic [31:0] m_tag [N];
    logic [31:0] m_tgt [N];
    int          m_ctr [N];
    int          m_ptr;

    always #5 clk = ~clk;

    brt_predictor u_brt_predictor (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_pred(logic [31:0] pc);
        int k = m_find(pc);
        if (k >= 0 && m_ctr[k] >= 2) return m_tgt[k];
        return pc + 32'd4;
    endfunction

    task automatic step(string tag, bit lv, logic [31:0] lpc, bit uv,
                        logic [31:0] upc, bit ut, logic [31:0] utg, logic [31:0] upred);
        int          k;
        bit          e_h, e_t;
        logic [31:0] e_npc, act_npc, e_rd;
        logic [1:0]  e_fl;
        lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_target = utg; upd_pred_npc = upred;
        k     = m_find(lpc);
        e_h   = lv && (k >= 0);
        e_t   = e_h && (m_ctr[k] >= 2);
        e_npc = !lv ? 32'd0 : (e_t ? m_tgt[k] : lpc + 32'd4);
        act_npc = ut ? utg : upc + 32'd4;
        e_fl  = (uv && act_npc != upred) ? 2'b11 : 2'b00;
        e_rd  = (e_fl != 0) ? act_npc : 32'd0;
        if (uv) begin
            k = m_find(upc);
            if (k >= 0) begin
                m_ctr[k] = ut ? ((m_ctr[k] == 3) ? 3 : m_ctr[k] + 1)
                              : ((m_ctr[k] == 0) ? 0 : m_ctr[k] - 1);
                if (ut) m_tgt[k] = utg;
            end else begin
                m_vld[m_ptr] = 1; m_tag[m_ptr] = upc; m_tgt[m_ptr] = utg;
                m_ctr[m_ptr] = 1; m_ptr = (m_ptr + 1) % N;
            end
        end
        @(negedge clk);
        chk(tag, "pred_valid", {31'd0, pred_valid_o}, {31'd0, lv});
        chk(tag, "pred_hit",   {31'd0, pred_hit_o},   {31'd0, e_h});
        chk(tag, "pred_taken", {31'd0, pred_taken_o}, {31'd0, e_t});
        chk(tag, "pred_npc",   pred_npc_o, e_npc);
        chk(tag, "flush",      {30'd0, flush_o}, {30'd0, e_fl});
        chk(tag, "redirect",   redirect_o, e_rd);
    endtask

    task automatic look(string tag, logic [31:0] pc);
        step(tag, 1, pc, 0, 0, 0, 0, 0);
    endtask

    task automatic train(string tag, logic [31:0] pc, bit t, logic [31:0] tg);
        step(tag, 0, 0, 1, pc, t, tg, m_pred(pc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0; end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "pred_valid", {31'd0, pred_valid_o}, 32'd0);
        chk("R1", "pred_npc",   pred_npc_o, 32'd0);
        chk("R1", "flush",      {30'd0, flush_o}, 32'd0);
        chk("R1", "redirect",   redirect_o, 32'd0);
        look("R1", 32'h0000_0100);               // empty table misses
        // R3 miss, R10 idle, R2 latency
        look("R3", 32'h0000_0abc);
        step("R10", 0, 32'h0000_0100, 0, 0, 0, 0, 0);
        look("R2", 32'h0000_0100);
        // R4 allocation with wrong prediction -> R8 flush
        step("R8", 0, 0, 1, 32'h0000_0100, 1, 32'h0000_0400, 32'h0000_0104);
        look("R4", 32'h0000_0100);
        step("R8", 0, 0, 1, 32'h0000_0100, 1, 32'h0000_0400, 32'h0000_0104);
        look("R5", 32'h0000_0100);
        // R5 counter walk: up to saturation and down to saturation
        for (int i = 0; i < 3; i++) begin
            train("R5", 32'h0000_0100, 1, 32'h0000_0400);
            look("R5", 32'h0000_0100);
        end
        for (int i = 0; i < 5; i++) begin
            train("R5", 32'h0000_0100, 0, 32'h0000_0400);
            look("R5", 32'h0000_0100);
        end
        // wrong prediction in the not-taken direction
        step("R8", 0, 0, 1, 32'h0000_0100, 0, 32'h0000_0400, 32'h0000_0400);
        // R6 target overwrite and keep
        for (int i = 0; i < 4; i++) train("R6", 32'h0000_0100, 1, 32'h0000_0800);
        look("R6", 32'h0000_0100);
        train("R6", 32'h0000_0100, 0, 32'h0000_0900);
        look("R6", 32'h0000_0100);                // still taken to 0x800
        // R9 same-cycle lookup and update
        step("R9", 1, 32'h0000_0100, 1, 32'h0000_0100, 0, 32'h0, m_pred(32'h0000_0100));
        look("R9", 32'h0000_0100);
        step("R9", 1, 32'h0000_0200, 1, 32'h0000_0200, 0, 32'h0000_0300, 32'h0000_0204);
        look("R9", 32'h0000_0200);
        // R7 fill past capacity, then sweep
        for (int i = 0; i < N; i++) train("R7", 32'h0000_1000 + 32'(i * 4), 0, 32'h0000_2000);
        look("R7", 32'h0000_0100);
        look("R7", 32'h0000_0200);
        for (int i = 0; i < N; i++) look("R7", 32'h0000_1000 + 32'(i * 4));
        train("R7", 32'h0000_3000, 1, 32'h0000_3300);
        for (int i = 0; i < 3; i++) look("R7", 32'h0000_1000 + 32'(i * 4));
        look("R4", 32'h0000_3000);
        step("R2", 0, 0, 0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule